// File: doc/BRIEF.md
# Bytecode Register-Write Sequencer

This block is a small engine that plays back a byte-coded script of register writes. A host first loads the script one 32-bit word at a time into a local program memory. Bytes are taken from each word with the least significant byte first. A start pulse then runs the script from byte 0. Each opcode patches an address latch or a data latch, drives one of 32 single-bit control flags, waits for a flag input to reach a value, or stalls for a coarse number of microseconds. Every address opcode fires one write of the data latch to the new address on a plain master write port.

Both latches persist between runs. A short opcode that patches only the low half of a latch can therefore reuse the upper half from an earlier write, which keeps scripts compact. A microsecond tick comes from the clock through a prescaler of `TICK_DIV` cycles. The engine is a five-state machine:
- IDLE waits for start.
- FETCH decodes one byte per cycle.
- OPERAND gathers the 2 or 4 operand bytes.
- FLAGWAIT stalls on a flag input.
- DELAY stalls on the timer.

The transitions are:
- IDLE to FETCH on start.
- FETCH to IDLE on the end byte or an undefined byte.
- FETCH to OPERAND on a multi-byte opcode.
- FETCH to DELAY on a delay with a non-zero mantissa.
- FETCH back to FETCH on a flag byte or a zero-mantissa delay.
- OPERAND to FETCH, or to FLAGWAIT for the wait opcode, after the last operand.
- FLAGWAIT to FETCH on a match.
- DELAY to FETCH on the last tick.

Top module: `regwr_sequencer`

## Requirements
- R1: A start pulse seen while idle raises busy in the next cycle, with execution from byte 0. A start pulse seen while busy has no effect.
- R2: Byte 0x7F ends the run. Busy is low and done is high for exactly one cycle, both in the cycle after that byte is decoded.
- R3: Opcode 0xE2 with 4 operand bytes (LSB first) loads the whole data latch. Opcode 0x42 with 2 operand bytes replaces only data bits 15:0 and keeps the upper half. Neither opcode writes on the bus.
- R4: Opcode 0xE0 (4 bytes) loads the whole address latch, and opcode 0x40 (2 bytes) replaces only its bits 15:0. Each raises bus_we for one cycle, in the cycle after its last operand byte, with bus_addr set to the new address and bus_data set to the data latch.
- R5: An opcode with L operand bytes occupies L+1 cycles, one byte per cycle.
- R6: A byte in the range 0x80 to 0xDF is a flag opcode. Bits 4:0 give the flag index and bits 6:5 give the mode. Mode 0 releases the flag (drive 0, level 0), mode 1 drives it low, and mode 2 drives it high. The outputs change in the cycle after the byte and the opcode takes one cycle.
- R7: Opcode 0x5F takes an index byte (bits 4:0) and a value byte (bit 0). It stalls until flag_in at that index equals the value bit, and takes at least 4 cycles.
- R8: A byte with bits 7:6 equal to 00 is a delay: shift is bits 5:2 and the mantissa is bits 1:0. The byte occupies 1 + mantissa·4^shift·TICK_DIV cycles, so a zero mantissa takes one cycle.
- R9: Any other byte is undefined. It ends the run with err high and no done pulse, and err clears when the next start is accepted.
- R10: Host word writes are stored only while idle, and byte k of a word is bits 8k+7:8k. A write while busy is dropped.
- R11: Reset clears busy, done, err, bus_we, both latches and all flag drive and level bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Program word write strobe |
| host_waddr | input | $clog2(PROG_WORDS) | Program word index |
| host_wdata | input | 32 | Program word |
| start | input | 1 | Start pulse |
| busy | output | 1 | Script running |
| done | output | 1 | One-cycle pulse on normal end |
| err | output | 1 | Last run hit an undefined byte |
| bus_we | output | 1 | Write strobe on the master port |
| bus_addr | output | 32 | Address latch |
| bus_data | output | 32 | Data latch |
| flag_in | input | 32 | Flag inputs tested by the wait opcode |
| flag_drive | output | 32 | Per-flag drive enable |
| flag_level | output | 32 | Per-flag driven level |

## Verification
The cycle timing is as follows:
- Busy rises one cycle after start.
- A write strobe appears one cycle after the last operand byte of an address opcode.
- A flag output changes one cycle after its byte.
- A match on a flag wait releases the engine one cycle after it is seen.
- A delay ends 1 + N·TICK_DIV cycles after its byte.

A behavioural model in the bench interprets the same byte image with these costs as stall counts and applies each effect on the edge where it is due. Every output is compared against the model at each falling edge. Directed runs then count busy cycles against hand-computed totals, and check the write log and the flag state at the end of each run.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPND,
        ST_WAIT,
        ST_DELAY
    } seq_state_e;

    localparam logic [7:0] OPC_STOP   = 8'h7F;
    localparam logic [7:0] OPC_DATA_W = 8'hE2;
    localparam logic [7:0] OPC_DATA_L = 8'h42;
    localparam logic [7:0] OPC_ADDR_W = 8'hE0;
    localparam logic [7:0] OPC_ADDR_L = 8'h40;
    localparam logic [7:0] OPC_WAITF  = 8'h5F;

    localparam int FLAG_IDX_W = 5;
    localparam int NUM_FLAGS  = 1 << FLAG_IDX_W;

    // number of operand bytes after an opcode; 0 for single-byte opcodes
    function automatic logic [2:0] opnd_count(input logic [7:0] opc);
        case (opc)
            OPC_DATA_W, OPC_ADDR_W:            opnd_count = 3'd4;
            OPC_DATA_L, OPC_ADDR_L, OPC_WAITF: opnd_count = 3'd2;
            default:                           opnd_count = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/regseq_progmem.sv
module regseq_progmem #(
    parameter int WORDS = 64,
    localparam int WAW = $clog2(WORDS),
    localparam int BAW = WAW + 2
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [BAW-1:0] rd_baddr,
    output logic [7:0]     rd_byte
);
    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // little-endian byte pick from the addressed word
    assign rd_byte = mem_q[rd_baddr[BAW-1:2]][{rd_baddr[1:0], 3'b000} +: 8];
endmodule

// File: rtl/regseq_delay.sv
module regseq_delay #(
    parameter int TICK_DIV = 100,
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] amount,
    output logic        last
);
    logic [PW-1:0] presc_q;
    logic [31:0]   rem_q;
    logic          tick;

    assign tick = (presc_q == PW'(TICK_DIV - 1));
    assign last = (rem_q == 32'd1) && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            presc_q <= '0;
            rem_q   <= amount;
        end else if (rem_q != 32'd0) begin
            if (tick) begin
                presc_q <= '0;
                rem_q   <= rem_q - 32'd1;
            end else begin
                presc_q <= presc_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/regseq_flags.sv
module regseq_flags
    import regseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [FLAG_IDX_W-1:0] idx,
    input  logic [1:0]            mode,
    output logic [NUM_FLAGS-1:0]  drive,
    output logic [NUM_FLAGS-1:0]  level
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drive[g] <= 1'b0;
                level[g] <= 1'b0;
            end else if (set_en && idx == FLAG_IDX_W'(g)) begin
                drive[g] <= (mode != 2'd0);
                level[g] <= (mode == 2'd2);
            end
        end
    end
endmodule

// File: rtl/regwr_sequencer.sv
module regwr_sequencer
    import regseq_pkg::*;
#(
    parameter int PROG_WORDS = 64,
    parameter int TICK_DIV   = 100,
    localparam int WAW = $clog2(PROG_WORDS),
    localparam int BAW = WAW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [WAW-1:0]       host_waddr,
    input  logic [31:0]          host_wdata,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 bus_we,
    output logic [31:0]          bus_addr,
    output logic [31:0]          bus_data,
    input  logic [NUM_FLAGS-1:0] flag_in,
    output logic [NUM_FLAGS-1:0] flag_drive,
    output logic [NUM_FLAGS-1:0] flag_level
);
    seq_state_e state_q, state_d;

    logic [BAW-1:0]        pc_q;
    logic [7:0]            cur;
    logic [7:0]            op_q;
    logic [1:0]            oidx_q;
    logic [31:0]           acc_q, acc_nx;
    logic [31:0]           addr_q, data_q;
    logic [FLAG_IDX_W-1:0] widx_q;
    logic                  wval_q;
    logic                  is_stop, is_multi, is_flag, is_delay, last_opnd;
    logic                  tmr_last, flag_set, dly_load;
    logic [31:0]           dly_amount;

    regseq_progmem #(.WORDS(PROG_WORDS)) u_mem (
        .clk      (clk),
        .wr_en    (host_we && state_q == ST_IDLE),
        .wr_addr  (host_waddr),
        .wr_data  (host_wdata),
        .rd_baddr (pc_q),
        .rd_byte  (cur)
    );

    // decode of the byte under the program counter
    assign is_stop    = (cur == OPC_STOP);
    assign is_multi   = (opnd_count(cur) != 3'd0);
    assign is_flag    = cur[7] && (cur[6:5] != 2'b11);
    assign is_delay   = (cur[7:6] == 2'b00);
    assign dly_amount = 32'(cur[1:0]) << {cur[5:2], 1'b0};
    assign flag_set   = (state_q == ST_FETCH) && is_flag;
    assign dly_load   = (state_q == ST_FETCH) && is_delay;
    assign last_opnd  = ({1'b0, oidx_q} == opnd_count(op_q) - 3'd1);
    assign acc_nx     = acc_q | (32'(cur) << {oidx_q, 3'b000});

    regseq_delay #(.TICK_DIV(TICK_DIV)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (dly_load),
        .amount (dly_amount),
        .last   (tmr_last)
    );

    regseq_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (flag_set),
        .idx    (cur[FLAG_IDX_W-1:0]),
        .mode   (cur[6:5]),
        .drive  (flag_drive),
        .level  (flag_level)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: begin
                if (is_stop)       state_d = ST_IDLE;
                else if (is_multi) state_d = ST_OPND;
                else if (is_flag)  state_d = ST_FETCH;
                else if (is_delay) state_d = (cur[1:0] != 2'd0) ? ST_DELAY : ST_FETCH;
                else               state_d = ST_IDLE;
            end
            ST_OPND:  if (last_opnd) state_d = (op_q == OPC_WAITF) ? ST_WAIT : ST_FETCH;
            ST_WAIT:  if (flag_in[widx_q] == wval_q) state_d = ST_FETCH;
            ST_DELAY: if (tmr_last) state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            op_q   <= '0;
            oidx_q <= '0;
            acc_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            widx_q <= '0;
            wval_q <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            bus_we <= 1'b0;
        end else begin
            done   <= 1'b0;
            bus_we <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q <= '0;
                        err  <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    pc_q   <= pc_q + BAW'(1);
                    op_q   <= cur;
                    oidx_q <= '0;
                    acc_q  <= '0;
                    if (is_stop) done <= 1'b1;
                    else if (!is_multi && !is_flag && !is_delay) err <= 1'b1;
                end
                ST_OPND: begin
                    pc_q   <= pc_q + BAW'(1);
                    oidx_q <= oidx_q + 2'd1;
                    acc_q  <= acc_nx;
                    if (last_opnd) begin
                        case (op_q)
                            OPC_DATA_W: data_q <= acc_nx;
                            OPC_DATA_L: data_q[15:0] <= acc_nx[15:0];
                            OPC_ADDR_W: begin
                                addr_q <= acc_nx;
                                bus_we <= 1'b1;
                            end
                            OPC_ADDR_L: begin
                                addr_q[15:0] <= acc_nx[15:0];
                                bus_we       <= 1'b1;
                            end
                            default: begin
                                widx_q <= acc_nx[FLAG_IDX_W-1:0];
                                wval_q <= acc_nx[8];
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign bus_addr = addr_q;
    assign bus_data = data_q;
endmodule

// File: rtl/regwr_sequencer_chk.sv
module regwr_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic bus_we
);
    a_r1_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    a_r2_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_write_inside_run: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> busy);

    a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !done));
endmodule

bind regwr_sequencer regwr_sequencer_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .bus_we (bus_we)
);

// File: tb/regwr_sequencer_tb_top.sv
module regwr_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int NB         = WORDS * 4;
    localparam int TICK       = 4;
    localparam int WAW        = $clog2(WORDS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [WAW-1:0] host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic        start = 1'b0;
    logic [31:0] flag_in = '0;
    logic        busy, done, err, bus_we;
    logic [31:0] bus_addr, bus_data, flag_drive, flag_level;

    regwr_sequencer #(.PROG_WORDS(WORDS), .TICK_DIV(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .start(start), .busy(busy), .done(done),
        .err(err), .bus_we(bus_we), .bus_addr(bus_addr), .bus_data(bus_data),
        .flag_in(flag_in), .flag_drive(flag_drive), .flag_level(flag_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  mb [NB];
    bit          m_busy, m_done, m_err, m_we, m_wait, m_wv;
    logic [31:0] m_addr, m_data, m_drv, m_lvl, m_pv;
    int          m_pc, m_stall, m_pend, m_wi;

    function automatic logic [7:0] mbyte(input int k);
        return mb[(m_pc + k) % NB];
    endfunction

    task automatic m_apply();
        case (m_pend)
            1: m_data = m_pv;
            2: m_data = {m_data[31:16], m_pv[15:0]};
            3: begin m_addr = m_pv; m_we = 1; end
            4: begin m_addr = {m_addr[31:16], m_pv[15:0]}; m_we = 1; end
            5: begin m_wi = int'(m_pv[4:0]); m_wv = m_pv[8]; m_wait = 1; end
            default: ;
        endcase
        m_pend = 0;
    endtask

    task automatic m_step();
        logic [7:0] b;
        int n;
        b = mbyte(0);
        if (b == 8'h7F) begin
            m_busy = 0; m_done = 1;
        end else if (b == 8'hE2 || b == 8'hE0) begin
            m_pv = {mbyte(4), mbyte(3), mbyte(2), mbyte(1)};
            m_pend = (b == 8'hE2) ? 1 : 3;
            m_stall = 4; m_pc = (m_pc + 5) % NB;
        end else if (b == 8'h42 || b == 8'h40 || b == 8'h5F) begin
            m_pv = {16'h0, mbyte(2), mbyte(1)};
            m_pend = (b == 8'h42) ? 2 : (b == 8'h40) ? 4 : 5;
            m_stall = 2; m_pc = (m_pc + 3) % NB;
        end else if (b >= 8'h80 && b < 8'hE0) begin
            m_drv[b[4:0]] = (b[6:5] != 0);
            m_lvl[b[4:0]] = (b[6:5] == 2);
            m_pc = (m_pc + 1) % NB;
        end else if (b < 8'h40) begin
            n = int'(b[1:0]) * (4 ** int'(b[5:2]));
            m_stall = n * TICK; m_pend = 0;
            m_pc = (m_pc + 1) % NB;
        end else begin
            m_busy = 0; m_err = 1;
        end
    endtask

    always @(posedge clk) begin
        m_done = 0; m_we = 0;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_wait = 0; m_addr = 0; m_data = 0;
            m_drv = 0; m_lvl = 0; m_pc = 0; m_stall = 0; m_pend = 0;
        end else begin
            if (host_we && !m_busy)
                for (int k = 0; k < 4; k++) mb[int'(host_waddr) * 4 + k] = host_wdata[8*k +: 8];
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_pc = 0; m_stall = 0; m_wait = 0; m_err = 0; m_pend = 0;
                end
            end else if (m_stall > 0) begin
                m_stall--;
                if (m_stall == 0) m_apply();
            end else if (m_wait) begin
                if (flag_in[m_wi] == m_wv) m_wait = 0;
            end else begin
                m_step();
            end
        end
    end

    // ---------------- per-clock comparison and monitor ----------------
    bit          saw_done;
    int          n_writes;
    logic [31:0] last_addr, last_data;

    always @(negedge clk) begin
        if (cmp_en) begin
            check(busy == m_busy, "R1 R5 R7 R8 busy", 32'(busy), 32'(m_busy));
            check(done == m_done, "R2 done", 32'(done), 32'(m_done));
            check(err == m_err, "R9 err", 32'(err), 32'(m_err));
            check(bus_we == m_we, "R4 bus_we", 32'(bus_we), 32'(m_we));
            check(bus_addr == m_addr, "R4 bus_addr", bus_addr, m_addr);
            check(bus_data == m_data, "R3 bus_data", bus_data, m_data);
            check(flag_drive == m_drv, "R6 flag_drive", flag_drive, m_drv);
            check(flag_level == m_lvl, "R6 flag_level", flag_level, m_lvl);
        end
        if (done) saw_done = 1;
        if (bus_we) begin
            n_writes++; last_addr = bus_addr; last_data = bus_data;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- program building and running ----------------
    logic [7:0] pb [NB];
    int pp;

    task automatic pclr();
        for (int i = 0; i < NB; i++) pb[i] = 8'h7F;
        pp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        pb[pp] = b; pp++;
    endtask

    task automatic load();
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            host_we = 1; host_waddr = WAW'(w);
            host_wdata = {pb[4*w+3], pb[4*w+2], pb[4*w+1], pb[4*w]};
        end
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic run(output int cyc, input int poke_start, input int poke_wr);
        saw_done = 0; n_writes = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        cyc = 0;
        while (busy && cyc < 60000) begin
            cyc++;
            start = (cyc == poke_start);
            host_we = (cyc == poke_wr); host_waddr = '0; host_wdata = 32'h7F7F7F7F;
            @(negedge clk);
        end
        start = 0; host_we = 0;
        if (busy) check(0, "R1 run timeout", 32'(cyc), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && bus_we == 0, "R11 reset control",
              {busy, done, err, bus_we}, 32'h0);
        check(flag_drive == 0 && flag_level == 0, "R11 reset flags", flag_drive | flag_level, 32'h0);
        check(bus_addr == 0 && bus_data == 0, "R11 reset latches", bus_addr | bus_data, 32'h0);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;

        // mixed program: full/low data and address, flags, delays, passing wait
        pclr();
        put(8'hE2); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
        put(8'hE0); put(8'h10); put(8'h00); put(8'hBB); put(8'hAA);
        put(8'h42); put(8'hEF); put(8'hBE);
        put(8'h40); put(8'h20); put(8'h00);
        put(8'h40); put(8'h30); put(8'h00);
        put(8'hA5); put(8'hC7); put(8'h85); put(8'hC5);
        put(8'h01); put(8'h06); put(8'h00);
        put(8'h5F); put(8'h07); put(8'h00);
        load();
        run(c, -1, -1);
        check(c == 67, "R5 R8 mixed program busy cycles", 32'(c), 32'd67);
        check(n_writes == 3, "R4 write count", 32'(n_writes), 32'd3);
        check(last_addr == 32'hAABB0030, "R4 low-half address patch", last_addr, 32'hAABB0030);
        check(last_data == 32'h1234BEEF, "R3 low-half data patch", last_data, 32'h1234BEEF);
        check(flag_drive == 32'hA0 && flag_level == 32'hA0, "R6 flag state",
              flag_drive ^ flag_level ^ 32'hA0, 32'hA0);
        check(saw_done == 1, "R2 done pulse seen", 32'(saw_done), 32'd1);

        // little-endian full loads, data-only opcode issues no write
        pclr();
        put(8'hE2); put(8'h44); put(8'h33); put(8'h22); put(8'h11);
        load();
        run(c, -1, -1);
        check(c == 6, "R5 four-operand cost", 32'(c), 32'd6);
        check(n_writes == 0, "R3 data opcode writes nothing", 32'(n_writes), 32'd0);
        check(bus_data == 32'h11223344, "R10 byte order", bus_data, 32'h11223344);

        // long delay, with a start and a host write poked while busy
        pclr(); put(8'h0D);
        load();
        run(c, 10, 20);
        check(c == 258, "R1 R8 delay with ignored start", 32'(c), 32'd258);
        run(c, -1, -1);
        check(c == 258, "R10 write while busy dropped", 32'(c), 32'd258);

        // wait that blocks until the flag input changes
        pclr(); put(8'h5F); put(8'h03); put(8'h01);
        load();
        flag_in = 32'h0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        check(busy == 1, "R7 stalled on flag", 32'(busy), 32'd1);
        flag_in = 32'h8;
        repeat (4) @(negedge clk);
        check(busy == 0, "R7 released by flag", 32'(busy), 32'd0);
        run(c, -1, -1);
        check(c == 5, "R7 wait with flag already matching", 32'(c), 32'd5);

        // undefined bytes
        pclr(); put(8'h81); put(8'h41);
        load();
        run(c, -1, -1);
        check(err == 1 && saw_done == 0, "R9 undefined byte stops with err",
              {err, saw_done}, 32'h2);
        check(c == 2, "R9 stop cycle", 32'(c), 32'd2);
        pclr(); put(8'hF0);
        load();
        run(c, -1, -1);
        check(err == 1, "R9 undefined high byte", 32'(err), 32'd1);
        pclr(); put(8'hC1);
        load();
        run(c, -1, -1);
        check(err == 0 && saw_done == 1, "R9 err cleared by next start", {err, saw_done}, 32'h1);
        check(flag_level[1] == 1, "R6 mode 2 drives high", 32'(flag_level[1]), 32'd1);

        cmp_en = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule